// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Add Unit

This unit treats each of two 32-bit operands as a pair of signed 16-bit halves. It multiplies low half by low half and high half by high half, then combines the two products. Add mode sums them and subtract mode takes the high product away from the low product. When accumulation is enabled, a 32-bit accumulator value is added to that result. All results wrap modulo 2^32 and are never saturated.

A sticky overflow flag records any signed 32-bit overflow. The flag can be raised by the product sum itself, not only by the accumulator addition. The case where both operands hold the most negative value in every half is the one that matters: each product is 0x40000000 and their sum is 0x80000000. That sum fits in 32 bits as a bit pattern but is a signed overflow, so it must set the flag.

Operands and controls are captured on a cycle with `in_valid` high. The result, the updated flag and a one-cycle `out_valid` pulse appear on the following cycle. Software-style clearing of the flag is done through `flag_clr`.

Top module: `dmac16_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, and on the first cycle after it, `result` is 0, `ovf_flag` is 0 and `out_valid` is 0.
- R2: The low product is the signed product of `op_a[15:0]` and the low lane of the second operand. The high product is the signed product of `op_a[31:16]` and the high lane of the second operand.
- R3: With `swap_b` = 1, the second operand lanes are exchanged before multiplication. The low lane is then `op_b[31:16]` and the high lane is `op_b[15:0]`. With `swap_b` = 0, they are used in place.
- R4: With `sub_mode` = 1, the result is the low product minus the high product. This difference never sets the flag.
- R5: With `sub_mode` = 0, the products are summed. A sum outside the signed 32-bit range sets the flag. For example, `op_a` = `op_b` = 0x80008000 gives result 0x80000000 and sets the flag.
- R6: With `acc_en` = 1, `acc_in` is added to the product result. Signed overflow of this addition also sets the flag. With `acc_en` = 0, `acc_in` has no effect.
- R7: Every result is the two's-complement wrapped value modulo 2^32. This holds even when one or both additions overflow, and in that case the flag is set once.
- R8: The flag is sticky. Once set, it stays set through later operations, overflowing or not, until `flag_clr` is asserted.
- R9: `flag_clr` = 1 at a clock edge clears the flag, with or without `in_valid`. Clear wins over a set caused by an operation in the same cycle.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` holds its last value while no operation is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture an operation this cycle |
| op_a | input | 32 | First operand, two signed halves |
| op_b | input | 32 | Second operand, two signed halves |
| acc_in | input | 32 | Accumulator addend |
| swap_b | input | 1 | Exchange the halves of `op_b` |
| sub_mode | input | 1 | 1: subtract the products, 0: add them |
| acc_en | input | 1 | Add `acc_in` to the product result |
| flag_clr | input | 1 | Clear the sticky overflow flag |
| result | output | 32 | Wrapped 32-bit result |
| ovf_flag | output | 1 | Sticky signed overflow flag |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Two things can meet at the same clock edge: an operation whose own addition overflows, and a flag clear. The bench provokes this by issuing the minimum-value operands with `flag_clr` held high in the capture cycle. It expects the flag to read 0 on the result cycle while the wrapped result still appears. A second collision is both additions overflowing in one operation: the minimum-value products are summed with a 0x80000000 accumulator. That case is judged on a wrapped result of 0 and a single, set flag.

// File: rtl/dmac16_pkg.sv
// Shared types for the dual halfword multiply-add unit.
// Assumes nothing beyond the field layout defined here.
package dmac16_pkg;

    // Per-operation control bits captured together with the operands
    typedef struct packed {
        logic swap;    // exchange halves of the second operand
        logic sub;     // subtract high product from low product
        logic acc;     // add the accumulator term
    } dmac16_ctrl_t;

    // Lane indices of the two halfword products
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
    localparam int NUM_LANES = 2;

endpackage

// File: rtl/dmac16_lanemul.sv
// Two signed halfword multipliers. The second operand's halves may be
// exchanged before use. Assumes products of two HALF_W signed values fit in
// 2*HALF_W bits, which holds for every input pair, including min*min.
module dmac16_lanemul #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0]        a_word,
    input  logic [WORD_W-1:0]        b_word,
    input  logic                     swap,
    output logic signed [WORD_W-1:0] prod_lo,
    output logic signed [WORD_W-1:0] prod_hi
);
    import dmac16_pkg::*;

    logic signed [WORD_W-1:0] prods [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] a_half;
        logic signed [HALF_W-1:0] b_half;

        // Pick the operand halves for this lane, honouring the swap control
        always_comb begin
            a_half = a_word[g*HALF_W +: HALF_W];
            if (swap) b_half = b_word[(NUM_LANES-1-g)*HALF_W +: HALF_W];
            else      b_half = b_word[g*HALF_W +: HALF_W];
        end

        // Signed product, sign-extended into the full word width
        assign prods[g] = WORD_W'(a_half) * WORD_W'(b_half);
    end

    assign prod_lo = prods[LANE_LO];
    assign prod_hi = prods[LANE_HI];
endmodule

// File: rtl/dmac16_combine.sv
// Adds or subtracts the two lane products in WORD_W bits, wrapping.
// Reports signed overflow using one sign-based test for both modes. Assumes
// the high product is never the most negative word, so negating it is exact.
module dmac16_combine #(
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [WORD_W-1:0] prod_lo,
    input  logic signed [WORD_W-1:0] prod_hi,
    input  logic                     sub,
    output logic [WORD_W-1:0]        comb_out,
    output logic                     comb_ovf
);
    logic [WORD_W-1:0] addend;

    // Form the second term: the high product, negated in subtract mode
    always_comb begin
        addend   = sub ? (~prod_hi + 1'b1) : prod_hi;
        comb_out = prod_lo + addend;
        comb_ovf = (prod_lo[WORD_W-1] == addend[WORD_W-1])
                && (comb_out[WORD_W-1] != prod_lo[WORD_W-1]);
    end

    // R4: the product difference can never leave the signed range
    assert_sub_no_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> !comb_ovf);
endmodule

// File: rtl/dmac16_accum.sv
// Optional second addition of an accumulator term onto the product result.
// Wraps modulo 2^WORD_W and reports signed overflow of this addition only.
module dmac16_accum #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] acc_term,
    input  logic              acc_en,
    output logic [WORD_W-1:0] acc_out,
    output logic              acc_ovf
);
    logic [WORD_W-1:0] sum_raw;

    // Add the accumulator when enabled; pass the base through otherwise
    always_comb begin
        sum_raw = base + acc_term;
        acc_out = acc_en ? sum_raw : base;
        acc_ovf = acc_en
               && (base[WORD_W-1] == acc_term[WORD_W-1])
               && (sum_raw[WORD_W-1] != base[WORD_W-1]);
    end
endmodule

// File: rtl/dmac16_top.sv
// Dual halfword signed multiply-add with optional accumulate and a sticky
// signed-overflow flag. Computes combinationally from the inputs and
// registers the result on the capture edge. The output is therefore valid
// one cycle after in_valid. flag_clr works on any cycle and wins over set.
module dmac16_top #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              swap_b,
    input  logic              sub_mode,
    input  logic              acc_en,
    input  logic              flag_clr,
    output logic [WORD_W-1:0] result,
    output logic              ovf_flag,
    output logic              out_valid
);
    import dmac16_pkg::*;

    dmac16_ctrl_t             ctrl;
    logic signed [WORD_W-1:0] p_lo;
    logic signed [WORD_W-1:0] p_hi;
    logic [WORD_W-1:0]        comb_val;
    logic                     comb_ovf;
    logic [WORD_W-1:0]        final_val;
    logic                     acc_ovf;
    logic [WORD_W-1:0]        result_q;
    logic                     flag_q;
    logic                     valid_q;

    // Bundle the per-operation controls
    assign ctrl = '{swap: swap_b, sub: sub_mode, acc: acc_en};

    dmac16_lanemul #(.HALF_W(HALF_W)) u_mul (
        .a_word (op_a),
        .b_word (op_b),
        .swap   (ctrl.swap),
        .prod_lo(p_lo),
        .prod_hi(p_hi)
    );

    dmac16_combine #(.WORD_W(WORD_W)) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .prod_lo (p_lo),
        .prod_hi (p_hi),
        .sub     (ctrl.sub),
        .comb_out(comb_val),
        .comb_ovf(comb_ovf)
    );

    dmac16_accum #(.WORD_W(WORD_W)) u_acc (
        .base    (comb_val),
        .acc_term(acc_in),
        .acc_en  (ctrl.acc),
        .acc_out (final_val),
        .acc_ovf (acc_ovf)
    );

    // Capture the result and the valid pulse for each accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) result_q <= final_val;
        end
    end

    // Sticky flag: clear has priority, otherwise OR in either overflow
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_clr) flag_q <= 1'b0;
        else if (in_valid && (comb_ovf || acc_ovf)) flag_q <= 1'b1;
    end

    assign result    = result_q;
    assign ovf_flag  = flag_q;
    assign out_valid = valid_q;

    // R10: a captured operation yields a valid pulse on the next cycle
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10: no pulse without a captured operation
    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: result is held between operations
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R8: a set flag survives any cycle without a clear
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    // R9: a clear always leaves the flag low
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !ovf_flag);
    // R5: the flag only rises after an accepted operation
    assert_flag_rise_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !in_valid) |=> !ovf_flag);
endmodule

// File: tb/sim_dmac16_top.sv
// Scoreboard bench: the driver computes expected items from the requirements
// and queues them; the monitor pops and compares on every out_valid.
module sim_dmac16_top;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    typedef struct {
        logic [31:0] res;
        bit          flag;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
    logic        swap_b = 1'b0, sub_mode = 1'b0, acc_en = 1'b0, flag_clr = 1'b0;
    logic [31:0] result;
    logic        ovf_flag, out_valid;

    int   checks = 0;
    int   errors = 0;
    bit   model_flag = 1'b0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    dmac16_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .swap_b(swap_b), .sub_mode(sub_mode), .acc_en(acc_en),
        .flag_clr(flag_clr),
        .result(result), .ovf_flag(ovf_flag), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Reference arithmetic in 64-bit signed integers
    function automatic void model(input logic [31:0] a, b, acc,
                                  input bit sw, sb, ae,
                                  output logic [31:0] r, output bit ov);
        logic [31:0] bb;
        longint p0, p1, s, t;
        bb = sw ? {b[15:0], b[31:16]} : b;
        p0 = longint'($signed(a[15:0]))  * longint'($signed(bb[15:0]));
        p1 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        s  = sb ? p0 - p1 : p0 + p1;
        ov = (s > SMAX) || (s < SMIN);
        r  = s[31:0];
        if (ae) begin
            t  = longint'($signed(r)) + longint'($signed(acc));
            ov = ov || (t > SMAX) || (t < SMIN);
            r  = t[31:0];
        end
    endfunction

    // Driver: issue one operation and queue its expected outcome
    task automatic send(input logic [31:0] a, b, acc, input bit sw, sb, ae,
                        input bit clr, input string tag);
        exp_t e;
        bit   ov;
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc;
        swap_b = sw; sub_mode = sb; acc_en = ae; flag_clr = clr;
        in_valid = 1'b1;
        model(a, b, acc, sw, sb, ae, e.res, ov);
        model_flag = clr ? 1'b0 : (model_flag | ov);
        e.flag = model_flag;
        e.tag  = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    // Clear the flag without an operation and verify it at the ports (R9)
    task automatic clear_only();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        #1;
        flag_clr = 1'b0;
        model_flag = 1'b0;
        @(negedge clk);
        check(ovf_flag == 1'b0, "R9 clear alone", {31'b0, ovf_flag}, 32'h0);
        check(out_valid == 1'b0, "R10 no pulse on clear", {31'b0, out_valid}, 32'h0);
    endtask

    // Monitor: compare each produced result with the head of the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected out_valid", result, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(result == e.res, {e.tag, " result"}, result, e.res);
                    check(ovf_flag == e.flag, {e.tag, " flag"},
                          {31'b0, ovf_flag}, {31'b0, e.flag});
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs are zero under reset
        check(result == 32'h0 && ovf_flag == 1'b0 && out_valid == 1'b0,
              "R1 reset state", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 32'h0 && ovf_flag == 1'b0 && out_valid == 1'b0,
              "R1 after release", result, 32'h0);

        // R2: lanewise products, positive and negative halves
        send(32'h0002_0003, 32'h0004_0005, 32'h0, 0, 0, 0, 0, "R2 basic");
        send(32'hFFFE_0007, 32'h0003_FFF9, 32'h0, 0, 0, 0, 0, "R2 signed");
        // R3: swap exchanges the second operand halves
        send(32'h0002_0003, 32'h0004_0005, 32'h0, 1, 0, 0, 0, "R3 swap");
        send(32'h0010_FFFF, 32'h8000_0100, 32'h0, 1, 1, 0, 0, "R3 swap sub");
        // R4: extreme difference stays in range, flag untouched
        send(32'h8000_8000, 32'h7FFF_8000, 32'h0, 0, 1, 0, 0, "R4 sub extreme");
        send(32'h8000_8000, 32'h8000_8000, 32'h0, 0, 1, 0, 0, "R4 sub min");
        // R5: minimum halves summed overflow to 0x80000000 and set the flag
        send(32'h8000_8000, 32'h8000_8000, 32'h0, 0, 0, 0, 0, "R5 min add");
        // R8: sticky across a harmless operation
        send(32'h0001_0001, 32'h0001_0001, 32'h0, 0, 0, 0, 0, "R8 sticky");
        clear_only();
        // R6: acc_in ignored when disabled, added when enabled
        send(32'h0001_0001, 32'h0001_0001, 32'h1234_5678, 0, 0, 0, 0, "R6 acc off");
        send(32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFF0, 0, 0, 1, 0, "R6 acc neg");
        send(32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h1000_0000, 0, 0, 1, 0, "R6 acc ovf");
        clear_only();
        // R7: both additions overflow, wrapped result is 0, flag set once
        send(32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 0, 0, 1, 0, "R7 double ovf");
        // R9: clear in the same cycle as an overflowing operation
        send(32'h8000_8000, 32'h8000_8000, 32'h0, 0, 0, 0, 1, "R9 clear vs set");
        // R7: assorted patterns against the reference arithmetic
        for (int i = 0; i < 24; i++) begin
            send($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), "R7 random");
        end
        // R10: result held and no pulse while idle
        repeat (2) @(negedge clk);
        begin
            logic [31:0] held;
            held = result;
            repeat (3) @(negedge clk);
            check(result == held, "R10 hold", result, held);
            check(out_valid == 1'b0, "R10 idle", {31'b0, out_valid}, 32'h0);
        end
        check(sb_q.size() == 0, "R10 all results seen", sb_q.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule